// File: doc/BRIEF.md
# Serial dot-array display controller

This block sits on the host side of a dot-array display built from clock-synchronised serial driver chips. A frame of on/off dot bits is written into an internal buffer through a one-bit write port. A start request then streams the frame out on a shift clock and serial data line that the block generates itself. After the last bit it pulses a level-sensitive latch control, which is transparent while high and holding while low, so the visible pattern changes only once per frame. A separate display-enable output is driven high unless a blank input forces it low.

The display has an upper and a lower array, each `DOTS_PER_ARRAY` dots long. In dual mode, two clock/data pairs shift both arrays at the same time. In chained mode, the upper array's serial output feeds the lower array's input, so a single pair carries one stream of twice the length. The lower-array bits go first in that stream so that they come to rest in the far register. The shift clock half-period is derived from the system clock frequency so that the shift rate never exceeds the driver limit.

Top module: `dotser_ctrl`

## Requirements
- R1: The shift clock half-period is HALF = ceil(SYS_CLK_HZ / (2 * MAX_SCLK_HZ)) system cycles (25 with the defaults), so consecutive rising edges are exactly 2*HALF cycles apart and the rate stays at or below MAX_SCLK_HZ.
- R2: A serial data output changes only while its shift clock is low; it holds its value for the whole high phase.
- R3: With chain_mode=0 each pair shows DOTS_PER_ARRAY rising edges; at rising edge n (from 0) sdat_a carries buffer address n and sdat_b carries address DOTS_PER_ARRAY+n, where 1 means dot on and 0 means dot off.
- R4: With chain_mode=1 only pair A shifts, with 2*DOTS_PER_ARRAY rising edges: the first DOTS_PER_ARRAY edges carry addresses DOTS_PER_ARRAY upward, the rest carry addresses 0 upward; sclk_b and sdat_b stay low.
- R5: latch is low during shifting, rises only after the final rising edge once the shift clock is low again, and stays high for exactly 2*HALF cycles.
- R6: busy is high from the cycle after an accepted start; done is a single-cycle pulse in the cycle where latch and busy fall together.
- R7: start and chain_mode are ignored while busy is high; the running transfer keeps its mode and length.
- R8: A write (wr_en) while idle stores wr_data at wr_addr (addresses 0..DOTS_PER_ARRAY-1 hold the upper array, the next DOTS_PER_ARRAY hold the lower array); a write while busy is dropped.
- R9: disp_en follows the inverse of blank one cycle later.
- R10: After reset and between transfers, sclk_a, sdat_a, sclk_b, sdat_b, latch, busy and done are low and disp_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Frame buffer write strobe |
| wr_addr | input | $clog2(2*DOTS_PER_ARRAY) | Dot address to write |
| wr_data | input | 1 | Dot value, 1 = on |
| start | input | 1 | Request to send the stored frame |
| chain_mode | input | 1 | 1 = single chained stream, 0 = two parallel pairs |
| blank | input | 1 | Forces the display enable low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| sclk_a | output | 1 | Shift clock, upper array or whole chain |
| sdat_a | output | 1 | Serial data, upper array or whole chain |
| sclk_b | output | 1 | Shift clock, lower array (dual mode) |
| sdat_b | output | 1 | Serial data, lower array (dual mode) |
| latch | output | 1 | Latch control, high = transparent |
| disp_en | output | 1 | Display enable, high = shown |

## Verification
Several properties are checked on every cycle: the quiet idle outputs, data stability while the shift clock is high, the minimum clock phase length, the latch staying low whenever the clock is high, the done pulse shape, and the frozen buffer and mode while busy. Only the bench scenarios can show that the right buffer bit arrives at each rising edge in each mode, and that the lower-first ordering holds in chained mode. They also show that the latch width and edge spacing are exact, and that writes and restarts made during a transfer leave no trace in the next frame.

// File: rtl/dotser_pkg.sv
package dotser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LATCH = 2'd2
    } seq_state_e;

    // Smallest half-period in system cycles that keeps the shift clock at or below max_hz.
    function automatic int half_ticks(input longint sys_hz, input longint max_hz);
        longint q;
        q = (sys_hz + 2 * max_hz - 1) / (2 * max_hz);
        if (q < 1) q = 1;
        return int'(q);
    endfunction

endpackage

// File: rtl/dotser_tick.sv
module dotser_tick #(
    parameter int HALF = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(HALF - 1));
        cnt_d = cnt_q;
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // A stopped divider restarts from zero, so the first phase is a full half-period (R1).
    p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick);

endmodule

// File: rtl/dotser_fbuf.sv
module dotser_fbuf #(
    parameter  int DOTS = 16,
    localparam int IW   = $clog2(2 * DOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic          wr_data,
    input  logic          hold,
    input  logic          rd_chain,
    input  logic [IW-1:0] rd_idx,
    output logic          bit_a,
    output logic          bit_b
);
    typedef struct packed {
        logic [DOTS-1:0] upper;
        logic [DOTS-1:0] lower;
    } fbuf_regs_t;

    fbuf_regs_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (wr_en && !hold) begin
            for (int i = 0; i < DOTS; i++) begin
                if (int'(wr_addr) == i)        buf_d.upper[i] = wr_data;
                if (int'(wr_addr) == DOTS + i) buf_d.lower[i] = wr_data;
            end
        end
    end

    // Stream position to buffer bit: chained streams start with the lower array.
    always_comb begin
        bit_a = 1'b0;
        bit_b = 1'b0;
        for (int i = 0; i < DOTS; i++) begin
            if (rd_chain) begin
                if (int'(rd_idx) == i)        bit_a = buf_q.lower[i];
                if (int'(rd_idx) == DOTS + i) bit_a = buf_q.upper[i];
            end else if (int'(rd_idx) == i) begin
                bit_a = buf_q.upper[i];
                bit_b = buf_q.lower[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    p_frozen_while_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(buf_q));

endmodule

// File: rtl/dotser_seq.sv
module dotser_seq
    import dotser_pkg::*;
#(
    parameter  int DOTS = 16,
    localparam int IW   = $clog2(2 * DOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          chain_mode,
    input  logic          tick,
    input  logic          bit_a,
    input  logic          bit_b,
    output logic [IW-1:0] rd_idx,
    output logic          rd_chain,
    output logic          run,
    output logic          busy,
    output logic          done,
    output logic          chain,
    output logic          sclk,
    output logic          sdat_a,
    output logic          sdat_b,
    output logic          latch
);
    localparam logic [IW-1:0] LAST_DUAL  = IW'(DOTS - 1);
    localparam logic [IW-1:0] LAST_CHAIN = IW'(2 * DOTS - 1);

    typedef struct packed {
        seq_state_e    st;
        logic [IW-1:0] idx;
        logic          chain;
        logic          sclk;
        logic          sa;
        logic          sb;
        logic          latch;
        logic          lat_ph;
        logic          busy;
        logic          done;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RESET = '{st: ST_IDLE, idx: '0, default: 1'b0};

    seq_regs_t s_d, s_q;
    logic [IW-1:0] last_idx;

    // Buffer read address for the bit that loads on this edge.
    always_comb begin
        if (s_q.st == ST_IDLE) begin
            rd_chain = chain_mode;
            rd_idx   = '0;
        end else begin
            rd_chain = s_q.chain;
            rd_idx   = (s_q.st == ST_SHIFT && tick && s_q.sclk) ? s_q.idx + 1'b1 : s_q.idx;
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        last_idx = s_q.chain ? LAST_CHAIN : LAST_DUAL;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st    = ST_SHIFT;
                    s_d.busy  = 1'b1;
                    s_d.chain = chain_mode;
                    s_d.idx   = '0;
                    s_d.sclk  = 1'b0;
                    s_d.sa    = bit_a;
                    s_d.sb    = bit_b;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!s_q.sclk) begin
                        s_d.sclk = 1'b1;
                    end else begin
                        s_d.sclk = 1'b0;
                        if (s_q.idx == last_idx) begin
                            s_d.st     = ST_LATCH;
                            s_d.latch  = 1'b1;
                            s_d.lat_ph = 1'b0;
                            s_d.sa     = 1'b0;
                            s_d.sb     = 1'b0;
                        end else begin
                            s_d.idx = s_q.idx + 1'b1;
                            s_d.sa  = bit_a;
                            s_d.sb  = bit_b;
                        end
                    end
                end
            end
            ST_LATCH: begin
                if (tick) begin
                    if (s_q.lat_ph) begin
                        s_d.st    = ST_IDLE;
                        s_d.latch = 1'b0;
                        s_d.busy  = 1'b0;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.lat_ph = 1'b1;
                    end
                end
            end
            default: s_d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= SEQ_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign run    = (s_q.st != ST_IDLE);
    assign busy   = s_q.busy;
    assign done   = s_q.done;
    assign chain  = s_q.chain;
    assign sclk   = s_q.sclk;
    assign sdat_a = s_q.sa;
    assign sdat_b = s_q.sb;
    assign latch  = s_q.latch;

    p_start_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start) |=> busy);

    p_mode_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(chain));

endmodule

// File: rtl/dotser_ctrl.sv
module dotser_ctrl
    import dotser_pkg::*;
#(
    parameter  int     DOTS_PER_ARRAY = 16,
    parameter  longint SYS_CLK_HZ     = 200_000_000,
    parameter  longint MAX_SCLK_HZ    = 4_000_000,
    localparam int     AW             = $clog2(2 * DOTS_PER_ARRAY)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_data,
    input  logic          start,
    input  logic          chain_mode,
    input  logic          blank,
    output logic          busy,
    output logic          done,
    output logic          sclk_a,
    output logic          sdat_a,
    output logic          sclk_b,
    output logic          sdat_b,
    output logic          latch,
    output logic          disp_en
);
    localparam int HALF = half_ticks(SYS_CLK_HZ, MAX_SCLK_HZ);

    logic          tick, run, rd_chain, chain, sclk;
    logic          bit_a, bit_b;
    logic [AW-1:0] rd_idx;
    logic          en_d, en_q;

    dotser_tick #(.HALF(HALF)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    dotser_fbuf #(.DOTS(DOTS_PER_ARRAY)) u_fbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .hold    (busy),
        .rd_chain(rd_chain),
        .rd_idx  (rd_idx),
        .bit_a   (bit_a),
        .bit_b   (bit_b)
    );

    dotser_seq #(.DOTS(DOTS_PER_ARRAY)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .chain_mode(chain_mode),
        .tick      (tick),
        .bit_a     (bit_a),
        .bit_b     (bit_b),
        .rd_idx    (rd_idx),
        .rd_chain  (rd_chain),
        .run       (run),
        .busy      (busy),
        .done      (done),
        .chain     (chain),
        .sclk      (sclk),
        .sdat_a    (sdat_a),
        .sdat_b    (sdat_b),
        .latch     (latch)
    );

    // Pair B is parked in chained mode; its data is already forced low by the buffer read.
    assign sclk_a = sclk;
    assign sclk_b = sclk & ~chain;

    always_comb begin
        en_d = ~blank;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b1;
        end else begin
            en_q <= en_d;
        end
    end

    assign disp_en = en_q;

    // Checker state: cycles since the shift clock last changed.
    logic sclk_prev_q;
    int   hold_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            hold_cnt_q  <= 0;
        end else begin
            sclk_prev_q <= sclk_a;
            if (sclk_a != sclk_prev_q)       hold_cnt_q <= 0;
            else if (hold_cnt_q < 1_000_000) hold_cnt_q <= hold_cnt_q + 1;
        end
    end

    p_low_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_a && !sclk_prev_q) |-> (hold_cnt_q >= HALF - 1));

    p_high_phase_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_a && sclk_prev_q) |-> (hold_cnt_q >= HALF - 1));

    p_data_a_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_a && $past(sclk_a)) |-> $stable(sdat_a));

    p_data_b_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_b && $past(sclk_b)) |-> $stable(sdat_b));

    p_chain_b_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && chain) |-> (!sclk_b && !sdat_b));

    p_latch_vs_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_a |-> !latch);

    p_done_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !latch && $past(busy) && $past(latch)));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk_a && !sdat_a && !sclk_b && !sdat_b && !latch));

endmodule

// File: tb/dotser_ctrl_test.sv
module dotser_ctrl_test;
    localparam int     DOTS = 16;
    localparam longint SYS  = 200_000_000;
    localparam longint MAXF = 4_000_000;
    localparam int     HALF = int'((SYS + 2 * MAXF - 1) / (2 * MAXF));
    localparam int     AW   = $clog2(2 * DOTS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_data = 1'b0, start = 1'b0, chain_mode = 1'b0, blank = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic busy, done, sclk_a, sdat_a, sclk_b, sdat_b, latch, disp_en;

    int checks = 0;
    int errors = 0;
    logic [2*DOTS-1:0] model = '0;

    always #2.5 clk = ~clk;

    dotser_ctrl #(.DOTS_PER_ARRAY(DOTS), .SYS_CLK_HZ(SYS), .MAX_SCLK_HZ(MAXF)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .start(start), .chain_mode(chain_mode), .blank(blank), .busy(busy), .done(done),
        .sclk_a(sclk_a), .sdat_a(sdat_a), .sclk_b(sclk_b), .sdat_b(sdat_b),
        .latch(latch), .disp_en(disp_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_a(input bit chained, input int n);
        if (!chained) return model[n];
        return (n < DOTS) ? model[DOTS + n] : model[n - DOTS];
    endfunction

    task automatic write_frame();
        for (int a = 0; a < 2 * DOTS; a++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = AW'(a); wr_data = model[a];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_xfer(input bit chained, input bit inject);
        int total, rises_a, rises_b, last_rise, lat_hi, cyc;
        bit prev_a, prev_b, cap_a, hold_ok, finished;
        string rq;
        total = chained ? 2 * DOTS : DOTS;
        rq = chained ? "R4" : "R3";
        @(negedge clk);
        start = 1'b1; chain_mode = chained;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R6 busy after start", int'(busy), 1);
        rises_a = 0; rises_b = 0; last_rise = 0; lat_hi = 0; cyc = 0;
        prev_a = sclk_a; prev_b = sclk_b; cap_a = 1'b0; hold_ok = 1'b1; finished = 1'b0;
        while (!finished && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (sclk_a && !prev_a) begin
                chk(sdat_a == exp_a(chained, rises_a), rq, int'(sdat_a), int'(exp_a(chained, rises_a)));
                chk(latch == 1'b0, "R5 latch low while shifting", int'(latch), 0);
                if (rises_a > 0) chk(cyc - last_rise == 2 * HALF, "R1 edge spacing", cyc - last_rise, 2 * HALF);
                last_rise = cyc; rises_a++; cap_a = sdat_a; hold_ok = 1'b1;
            end else if (sclk_a && prev_a) begin
                if (sdat_a != cap_a) hold_ok = 1'b0;
            end else if (!sclk_a && prev_a) begin
                chk(hold_ok, "R2 data held while clock high", int'(hold_ok), 1);
            end
            if (sclk_b && !prev_b) begin
                if (chained) chk(1'b0, "R4 pair B moved", 1, 0);
                else chk(sdat_b == model[DOTS + rises_b], "R3", int'(sdat_b), int'(model[DOTS + rises_b]));
                rises_b++;
            end
            if (inject && cyc == 40) begin
                wr_addr = AW'($urandom_range(2 * DOTS - 1, 0));
                wr_data = ~model[wr_addr];
                wr_en = 1'b1; start = 1'b1; chain_mode = ~chained;
            end
            if (inject && cyc == 41) begin
                wr_en = 1'b0; start = 1'b0; chain_mode = chained;
            end
            if (latch) begin
                if (lat_hi == 0) begin
                    chk(rises_a == total && !sclk_a, "R5 latch after last bit", rises_a, total);
                end
                lat_hi++;
            end
            if (done) begin
                chk(!busy && !latch, "R6 done with busy and latch low", int'(busy) + int'(latch), 0);
                chk(lat_hi == 2 * HALF, "R5 latch width", lat_hi, 2 * HALF);
                chk(rises_a == total, inject ? "R7 length kept" : rq, rises_a, total);
                chk(rises_b == (chained ? 0 : DOTS), inject ? "R7 mode kept" : rq, rises_b, chained ? 0 : DOTS);
                finished = 1'b1;
            end
            prev_a = sclk_a; prev_b = sclk_b;
        end
        chk(finished, "R6 transfer completes", int'(finished), 1);
        @(negedge clk);
        chk(!done && !busy && !sclk_a && !sdat_a && !sclk_b && !sdat_b && !latch,
            "R10 idle outputs", int'(done | busy | sclk_a | sdat_a | sclk_b | sdat_b | latch), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0a17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !sclk_a && !sdat_a && !sclk_b && !sdat_b && !latch,
            "R10 reset outputs", int'(busy | done | sclk_a | sdat_a | sclk_b | sdat_b | latch), 0);
        chk(disp_en == 1'b1, "R10 enable after reset", int'(disp_en), 1);

        blank = 1'b1;
        @(negedge clk);
        chk(disp_en == 1'b0, "R9 blank forces enable low", int'(disp_en), 0);
        blank = 1'b0;
        @(negedge clk);
        chk(disp_en == 1'b1, "R9 enable returns", int'(disp_en), 1);

        for (int k = 0; k < 8; k++) begin
            if (k == 0)      model = '0;
            else if (k == 1) model = '1;
            else if (k == 2) model = {DOTS{2'b10}};
            else if (k == 3) model = {{DOTS{1'b1}}, {DOTS{1'b0}}};
            else for (int a = 0; a < 2 * DOTS; a++) model[a] = 1'($urandom_range(1, 0));
            write_frame();
            run_xfer(k[0], k >= 4);
            if (k >= 4) begin
                // R8: the frame written while busy must come out unchanged.
                run_xfer(k[0], 1'b0);
            end
        end

        blank = 1'b1;
        run_xfer(1'b1, 1'b0);
        chk(disp_en == 1'b0, "R9 blank held through transfer", int'(disp_en), 0);
        blank = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule